// File: doc/BRIEF.md
# Prioritized Channel-Mapped Interrupt Controller

This block collects a parameterized number of interrupt sources (64 by default) and presents them to a processor on two host lines. Host 0 is the fast interrupt line and host 1 is the normal interrupt line.

Each source is first brought into the clock domain by a two-flop synchronizer. A per-source trigger mode then turns it into a status bit. Edge-mode status stays latched until software clears it. Level-mode status tracks the input on every cycle. The status is masked by a per-source enable.

Each source is steered to one of 32 priority channels. Each channel is in turn steered to one of the two hosts. For each host, a prioritized-index register reports the winning source: the lowest channel wins, and between sources on the same channel the lowest source number wins.

Software reaches the block through a single-cycle 32-bit register port addressed by word offset. Writes take effect at the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. Single bits are set or cleared by writing a source or host number to an index register. Word-wide clear registers take a mask of ones.

Top module: `prio_intc`

## Requirements
- R1: After reset, the global enable, both host enables, every source enable and every status bit are 0. Both outputs are low, and both prioritized-index registers read 0x8000_0000.
- R2: Each source i has a polarity bit at bit i%32 of word 0x18+i/32 and a type bit at the same position in word 0x1C+i/32. The encodings as {type,pol} are: 11 rising edge, 10 falling edge, 01 active-high level, 00 active-low level. The reset values are polarity 1 and type 0. Status is visible at bit i%32 of word 0x10+i/32, three clock edges after the input changes.
- R3: An edge-mode status bit stays set after its input returns to idle. It is cleared by writing the source number to offset 0x01, which clears no other bit.
- R4: Level-mode status follows the qualified input; a clear aimed at it has no lasting effect.
- R5: Writing a source number to 0x02 sets only that source's enable, and writing it to 0x03 clears only that enable. Enables read back at bit i%32 of word 0x14+i/32.
- R6: Writing a mask to 0x10+w clears status bits, and writing a mask to 0x14+w clears enable bits, wherever the mask has a 1. Bits where the mask has a 0 are unchanged.
- R7: Word 0x20+r holds the channel of sources 4r..4r+3, one byte per source with the lowest source in the low byte. Only the low 5 bits of each byte select the channel. The reset value of each byte is 0x0F.
- R8: Word 0x40+r holds the host of channels 4r..4r+3, with bit 0 of each byte (byte 0 for the lowest channel) selecting the host. At reset, channels 0 and 1 map to host 0 and channels 2 to 31 map to host 1.
- R9: Offset 0x07 (host 0) and offset 0x08 (host 1) report, among the pending and enabled sources whose channel maps to that host, the source on the lowest channel number. Ties go to the lowest source number. The register reads 0x8000_0000 when no source qualifies. The value does not depend on the global or host enables.
- R10: `fiq_o` (host 0) and `irq_o` (host 1) are each high when the global enable and that host's enable are set and that host's index register is valid. Writing the host number to 0x04 sets its enable, writing it to 0x05 clears it, and the enables read back at 0x06.
- R11: Bit 0 of offset 0x00 is the global enable; while it is 0 both outputs are low.
- R12: A write to an index register with a source or host number that is out of range changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Asynchronous interrupt source inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| fiq_o | output | 1 | Host 0 (fast) interrupt request |
| irq_o | output | 1 | Host 1 (normal) interrupt request |

## Verification
The bench uses an eight-source instance and covers each of the four trigger modes with all 256 input words applied in counting order. This separates rising edges from falling edges and separates latched status from level-following status. The prioritized-index registers and both host outputs are then compared against an arithmetic model over every pending-enable mask. This is repeated under several channel assignments that produce ties on the same channel, and under three channel-to-host maps, so that channel ordering, source tie-breaking and host steering are each exposed separately. Directed sequences cover single-bit index writes, partial word clears, out-of-range indices and gating by the global and host enables.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int CHAN_N  = 32;
    localparam int CHAN_W  = 5;
    localparam int HOSTS   = 2;
    localparam int IDX_W   = 7;    // up to 128 sources

    localparam logic [7:0] A_GLOBAL       = 8'h00;
    localparam logic [7:0] A_STAT_IDX_CLR = 8'h01;
    localparam logic [7:0] A_EN_IDX_SET   = 8'h02;
    localparam logic [7:0] A_EN_IDX_CLR   = 8'h03;
    localparam logic [7:0] A_HEN_IDX_SET  = 8'h04;
    localparam logic [7:0] A_HEN_IDX_CLR  = 8'h05;
    localparam logic [7:0] A_HEN          = 8'h06;
    localparam logic [7:0] A_PRI0         = 8'h07;
    localparam logic [7:0] A_PRI1         = 8'h08;
    localparam logic [7:0] A_STAT_BASE    = 8'h10;
    localparam logic [7:0] A_EN_BASE      = 8'h14;
    localparam logic [7:0] A_POL_BASE     = 8'h18;
    localparam logic [7:0] A_TYP_BASE     = 8'h1C;
    localparam logic [7:0] A_CMAP_BASE    = 8'h20;
    localparam logic [7:0] A_HMAP_BASE    = 8'h40;

    localparam logic [7:0] CMAP_RESET = 8'h0F;

    // encoded as {type, polarity}
    typedef enum logic [1:0] {
        TRIG_LVL_LOW  = 2'b00,
        TRIG_LVL_HIGH = 2'b01,
        TRIG_FALL     = 2'b10,
        TRIG_RISE     = 2'b11
    } trig_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] src;
    } pick_t;

    function automatic logic default_host(input int ch);
        return (ch >= 2);
    endfunction

    function automatic logic [31:0] pick_word(input pick_t p);
        return p.hit ? {{(32-IDX_W){1'b0}}, p.src} : 32'h8000_0000;
    endfunction
endpackage

// File: rtl/ic_detect.sv
module ic_detect
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] typ,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] stat
);
    logic [NUM_SRC-1:0] sync1, sync2, prev;
    logic [NUM_SRC-1:0] stat_next;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            unique case (trig_e'({typ[i], pol[i]}))
                TRIG_RISE:     stat_next[i] = (sync2[i] & ~prev[i]) | (stat[i] & ~clr[i]);
                TRIG_FALL:     stat_next[i] = (~sync2[i] & prev[i]) | (stat[i] & ~clr[i]);
                TRIG_LVL_HIGH: stat_next[i] = sync2[i];
                default:       stat_next[i] = ~sync2[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
            stat  <= '0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
            prev  <= sync2;
            stat  <= stat_next;
        end
    end
endmodule

// File: rtl/ic_pick.sv
module ic_pick
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int HOST    = 0
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0][CHAN_W-1:0] chan_of,
    input  logic [CHAN_N-1:0]              host_of,
    output pick_t                          pick
);
    logic [CHAN_W-1:0] best_chan;

    always_comb begin
        pick      = '0;
        best_chan = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (host_of[chan_of[i]] == 1'(HOST)) &&
                (!pick.hit || chan_of[i] < best_chan)) begin
                pick.hit  = 1'b1;
                pick.src  = IDX_W'(i);
                best_chan = chan_of[i];
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               fiq_o,
    output logic               irq_o
);
    logic                 glb_en;
    logic [HOSTS-1:0]     hen;
    logic [NUM_SRC-1:0]   en_q, en_next, pol_q, typ_q, stat, stat_clr, pend;
    logic [NUM_SRC-1:0][7:0]        cmap_q;
    logic [NUM_SRC-1:0][CHAN_W-1:0] chan_sel;
    logic [CHAN_N-1:0]    hmap_q;
    pick_t                picks [HOSTS];
    logic [HOSTS-1:0]     host_hit;

    ic_detect #(.NUM_SRC(NUM_SRC)) u_detect (
        .clk(clk), .rst(rst), .raw(src_in), .pol(pol_q), .typ(typ_q),
        .clr(stat_clr), .stat(stat)
    );

    assign pend = stat & en_q;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) chan_sel[i] = cmap_q[i][CHAN_W-1:0];
    end

    for (genvar h = 0; h < HOSTS; h++) begin : g_host
        ic_pick #(.NUM_SRC(NUM_SRC), .HOST(h)) u_pick (
            .pend(pend), .chan_of(chan_sel), .host_of(hmap_q), .pick(picks[h])
        );
        assign host_hit[h] = picks[h].hit;
    end

    assign fiq_o = glb_en & hen[0] & host_hit[0];
    assign irq_o = glb_en & hen[1] & host_hit[1];

    // status clears and enable updates from index and mask writes
    always_comb begin
        stat_clr = '0;
        en_next  = en_q;
        if (reg_wr) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (reg_addr == A_STAT_IDX_CLR && reg_wdata == 32'(i)) stat_clr[i] = 1'b1;
                if (reg_addr == A_STAT_BASE + 8'(i / 32) && reg_wdata[i % 32]) stat_clr[i] = 1'b1;
                if (reg_addr == A_EN_IDX_SET && reg_wdata == 32'(i)) en_next[i] = 1'b1;
                if (reg_addr == A_EN_IDX_CLR && reg_wdata == 32'(i)) en_next[i] = 1'b0;
                if (reg_addr == A_EN_BASE + 8'(i / 32) && reg_wdata[i % 32]) en_next[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en <= 1'b0;
            hen    <= '0;
            en_q   <= '0;
            pol_q  <= '1;
            typ_q  <= '0;
            for (int i = 0; i < NUM_SRC; i++) cmap_q[i] <= CMAP_RESET;
            for (int c = 0; c < CHAN_N; c++) hmap_q[c] <= default_host(c);
        end else begin
            en_q <= en_next;
            if (reg_wr) begin
                if (reg_addr == A_GLOBAL) glb_en <= reg_wdata[0];
                if (reg_addr == A_HEN_IDX_SET && reg_wdata < 32'(HOSTS)) hen[reg_wdata[0]] <= 1'b1;
                if (reg_addr == A_HEN_IDX_CLR && reg_wdata < 32'(HOSTS)) hen[reg_wdata[0]] <= 1'b0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (reg_addr == A_POL_BASE + 8'(i / 32)) pol_q[i] <= reg_wdata[i % 32];
                    if (reg_addr == A_TYP_BASE + 8'(i / 32)) typ_q[i] <= reg_wdata[i % 32];
                    if (reg_addr == A_CMAP_BASE + 8'(i / 4)) cmap_q[i] <= reg_wdata[(i % 4) * 8 +: 8];
                end
                for (int c = 0; c < CHAN_N; c++) begin
                    if (reg_addr == A_HMAP_BASE + 8'(c / 4)) hmap_q[c] <= reg_wdata[(c % 4) * 8];
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_GLOBAL: reg_rdata[0]         = glb_en;
            A_HEN:    reg_rdata[HOSTS-1:0] = hen;
            A_PRI0:   reg_rdata            = pick_word(picks[0]);
            A_PRI1:   reg_rdata            = pick_word(picks[1]);
            default:  ;
        endcase
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_addr == A_STAT_BASE + 8'(i / 32)) reg_rdata[i % 32] = stat[i];
            if (reg_addr == A_EN_BASE   + 8'(i / 32)) reg_rdata[i % 32] = en_q[i];
            if (reg_addr == A_POL_BASE  + 8'(i / 32)) reg_rdata[i % 32] = pol_q[i];
            if (reg_addr == A_TYP_BASE  + 8'(i / 32)) reg_rdata[i % 32] = typ_q[i];
            if (reg_addr == A_CMAP_BASE + 8'(i / 4))  reg_rdata[(i % 4) * 8 +: 8] = cmap_q[i];
        end
        for (int c = 0; c < CHAN_N; c++) begin
            if (reg_addr == A_HMAP_BASE + 8'(c / 4)) reg_rdata[(c % 4) * 8] = hmap_q[c];
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int NUM_SRC = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic               glb_en,
    input logic [1:0]         hen,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] typ_q,
    input logic [NUM_SRC-1:0] stat,
    input logic [1:0]         host_hit,
    input logic               fiq_o,
    input logic               irq_o
);
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!glb_en && hen == 2'b00 && en_q == '0 && stat == '0));

    p_global_gate_r11: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> (!fiq_o && !irq_o));

    p_fast_line_r10: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (host_hit[0] && hen[0]));

    p_normal_line_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (host_hit[1] && hen[1]));

    p_enable_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(en_q));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        p_edge_latch_r3: assert property (@(posedge clk) disable iff (rst)
            (typ_q[i] && stat[i] && !reg_wr) |=> stat[i]);
    end
endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .glb_en(glb_en), .hen(hen),
    .en_q(en_q), .typ_q(typ_q), .stat(stat), .host_hit(host_hit),
    .fiq_o(fiq_o), .irq_o(irq_o)
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src_in = '0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         fiq_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int ch_tb [N];
    logic hm_tb [32];

    always #2 clk = ~clk;

    prio_intc #(.NUM_SRC(N)) uut (
        .clk(clk), .rst(rst), .src_in(src_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fiq_o(fiq_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] exp_pick(input int h, input logic [N-1:0] pend);
        int best_c = 99;
        int best_s = -1;
        for (int s = 0; s < N; s++) begin
            if (pend[s] && int'(hm_tb[ch_tb[s]]) == h && ch_tb[s] < best_c) begin
                best_c = ch_tb[s];
                best_s = s;
            end
        end
        return (best_s < 0) ? 32'h8000_0000 : 32'(best_s);
    endfunction

    task automatic load_maps();
        for (int r = 0; r < N / 4; r++)
            wr(8'h20 + 8'(r), {8'(ch_tb[4*r+3]), 8'(ch_tb[4*r+2]), 8'(ch_tb[4*r+1]), 8'(ch_tb[4*r])});
        for (int r = 0; r < 8; r++)
            wr(8'h40 + 8'(r), {7'd0, hm_tb[4*r+3], 7'd0, hm_tb[4*r+2], 7'd0, hm_tb[4*r+1], 7'd0, hm_tb[4*r]});
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic [N-1:0] q;
        logic [N-1:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, d); chk("R1 global", d, 0);
        rd(8'h06, d); chk("R1 host enables", d, 0);
        rd(8'h14, d); chk("R1 enables", d, 0);
        rd(8'h10, d); chk("R1 status", d, 0);
        rd(8'h07, d); chk("R1 pri0", d, 32'h8000_0000);
        rd(8'h08, d); chk("R1 pri1", d, 32'h8000_0000);
        chk("R1 outputs", {30'd0, fiq_o, irq_o}, 0);
        rd(8'h18, d); chk("R2 reset polarity", d, 32'hFF);
        rd(8'h1C, d); chk("R2 reset type", d, 0);
        rd(8'h20, d); chk("R7 reset channel map", d, 32'h0F0F_0F0F);
        rd(8'h40, d); chk("R8 reset host map", d, 32'h0101_0000);

        // R2 sweep of all four trigger modes over every input word
        for (int m = 0; m < 4; m++) begin
            logic typ_b = m[1];
            logic pol_b = m[0];
            wr(8'h18, {32{pol_b}} & 32'hFF);
            wr(8'h1C, {32{typ_b}} & 32'hFF);
            src_in = '0;
            settle();
            wr(8'h10, 32'hFF);
            q = '0;
            for (int p = 0; p < 256; p++) begin
                src_in = N'(p);
                settle();
                if (!typ_b) e = pol_b ? N'(p) : ~N'(p);
                else        e = pol_b ? (N'(p) & ~q) : (~N'(p) & q);
                rd(8'h10, d);
                chk("R2 trigger mode status", d, 32'(e));
                if (typ_b) wr(8'h10, 32'hFF);
                q = N'(p);
            end
        end

        // rising mode, all status set
        wr(8'h18, 32'hFF); wr(8'h1C, 32'hFF);
        src_in = '0; settle(); wr(8'h10, 32'hFF);
        src_in = '1; settle();
        rd(8'h10, d); chk("R2 rising all", d, 32'hFF);
        wr(8'h10, 32'h0F);
        rd(8'h10, d); chk("R6 partial status clear", d, 32'hF0);
        wr(8'h01, 32'd5);
        rd(8'h10, d); chk("R3 index clear", d, 32'hD0);
        wr(8'h01, 32'd8);
        rd(8'h10, d); chk("R12 status index out of range", d, 32'hD0);
        src_in = '0; settle();
        rd(8'h10, d); chk("R3 latched after input idle", d, 32'hD0);

        // R4 level clear has no lasting effect
        wr(8'h1C, 32'h00);
        src_in = 8'h3C; settle();
        wr(8'h01, 32'd2);
        rd(8'h10, d); chk("R4 level status after clear", d, 32'h3C);

        // R5 enables
        wr(8'h02, 32'd1); wr(8'h02, 32'd6);
        rd(8'h14, d); chk("R5 index set", d, 32'h42);
        wr(8'h03, 32'd6);
        rd(8'h14, d); chk("R5 index clear", d, 32'h02);
        wr(8'h02, 32'd8);
        rd(8'h14, d); chk("R12 enable index out of range", d, 32'h02);
        wr(8'h02, 32'd7);
        wr(8'h14, 32'h80);
        rd(8'h14, d); chk("R6 partial enable clear", d, 32'h02);

        // priority sweep: rising mode, all status set
        wr(8'h1C, 32'hFF);
        src_in = '0; settle(); wr(8'h10, 32'hFF);
        src_in = '1; settle();
        wr(8'h00, 32'd1); wr(8'h04, 32'd0); wr(8'h04, 32'd1);
        for (int v = 0; v < 3; v++) begin
            for (int c = 0; c < 32; c++)
                hm_tb[c] = (v == 0) ? (c >= 2) : (v == 1) ? logic'(c % 2) : (c % 3 != 0);
            for (int k = 1; k < 5; k++) begin
                for (int s = 0; s < N; s++) ch_tb[s] = (s * k + v) % 9;
                load_maps();
                rd(8'h20, d);
                chk("R7 channel map readback", d,
                    {8'(ch_tb[3]), 8'(ch_tb[2]), 8'(ch_tb[1]), 8'(ch_tb[0])});
                for (int mk = 0; mk < 256; mk++) begin
                    logic [N-1:0] pm = N'(mk);
                    logic [31:0] e0, e1;
                    wr(8'h14, 32'hFF);
                    for (int s = 0; s < N; s++) if (pm[s]) wr(8'h02, 32'(s));
                    e0 = exp_pick(0, pm);
                    e1 = exp_pick(1, pm);
                    rd(8'h07, d); chk("R9 R8 pri host0", d, e0);
                    rd(8'h08, d); chk("R9 R8 pri host1", d, e1);
                    chk("R10 fiq", 32'(fiq_o), 32'(!e0[31]));
                    chk("R10 irq", 32'(irq_o), 32'(!e1[31]));
                end
            end
        end

        // R10 R11 gating
        for (int c = 0; c < 32; c++) hm_tb[c] = (c >= 2);
        for (int s = 0; s < N; s++) ch_tb[s] = 15;
        ch_tb[0] = 0; ch_tb[1] = 5;
        load_maps();
        wr(8'h14, 32'hFF); wr(8'h02, 32'd0); wr(8'h02, 32'd1);
        chk("R10 both lines", {30'd0, fiq_o, irq_o}, 32'h3);
        wr(8'h00, 32'd0);
        chk("R11 global off", {30'd0, fiq_o, irq_o}, 32'h0);
        rd(8'h07, d); chk("R9 index independent of global", d, 32'd0);
        rd(8'h08, d); chk("R9 host1 index", d, 32'd1);
        wr(8'h00, 32'd1);
        wr(8'h05, 32'd1);
        chk("R10 host1 disabled", {30'd0, fiq_o, irq_o}, 32'h2);
        rd(8'h06, d); chk("R10 host enable readback", d, 32'h1);
        wr(8'h05, 32'd0);
        wr(8'h04, 32'd5);
        rd(8'h06, d); chk("R12 host index out of range", d, 32'h0);
        chk("R10 both disabled", {30'd0, fiq_o, irq_o}, 32'h0);

        summary();
    end
endmodule